// File: doc/BRIEF.md
# Sample Delay Tracking Controller

This block keeps the capture point of a source-synchronous data bus centred while voltage and temperature drift. An external phase detector delivers measurement results (a setup delay, a hold delay, a proposed sample delay and a phase-correctness flag) through a request/valid handshake. The block smooths the proposed sample delay with an exponential average. The average is kept in a fixed-point accumulator, and its length is selected as a power-of-two shift. The rounded average is compared with the sample delay currently applied to the delay line.

Depending on the control register, the block runs a single measurement or measures without pause. In continuous mode it either moves the applied delay to the filtered value, or it raises a sticky interrupt once the distance between the two reaches a programmed threshold. A small register window gives access to the written values. It also gives access to the measured values, depending on the tracking mode.

Top module: `sdt_ctrl`

## Requirements
- R1: After reset, `sample_delay`, `irq` and `meas_req` are 0, and every register address reads 0.
- R2: With the continuous bit (control bit 7) at 0, writing 1 to bit 1 of address 3 raises `meas_req` on the next cycle. `meas_req` falls in the cycle after the accepted `meas_valid`. It does not rise again without another start.
- R3: With the continuous bit at 1, `meas_req` stays high across accepted results. If the bit is cleared while a request is open, that request still completes, and only then does `meas_req` fall.
- R4: `meas_valid` is ignored while `meas_req` is low. It changes neither the captured values nor the filter.
- R5: The filter accumulator holds 4 integer and 12 fractional bits. The first accepted result loads it directly. Each later result updates it as acc += (new − acc) >>> L, with L taken from control bits 5:2 and any value above 12 treated as 12. The filtered value is acc rounded half up, saturated at 15.
- R6: Address 0 reads {setup[7:4], hold[3:0]}. Address 1 reads {sample[7:4], change[3], 0, 0, check[0]}. When the tracking bit (control bit 6) is 1, these fields return the last captured setup and hold values and the filtered sample value. When it is 0, they return the last written values.
- R7: The change bit is set when an accepted result differs in any of setup, hold or sample from the previous accepted result. It is 0 after the first result.
- R8: The check bit holds the phase-correct flag of the last accepted result.
- R9: The drift is |filtered − applied|. Threshold code T (control bits 1:0) fires when the drift is at least T+1.
- R10: Tracking is effective only when the tracking bit is 1, the continuous bit is 1 and `irq_en` is 0. When it is effective, the cycle after an accepted result moves `sample_delay` to the filtered value if the threshold fires. At no other time does the filter alter `sample_delay`.
- R11: When the continuous bit is 1 and tracking is not effective, a firing threshold sets a sticky flag, which reads at address 3 bit 0. Writing 1 to address 3 bit 0 clears the flag. `irq` equals the flag gated by `irq_en`.
- R12: Writing address 1 loads bits 7:4 into `sample_delay` and into the written sample value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Combinational readback |
| irq_en | input | 1 | Interrupt enable; also blocks tracking |
| meas_req | output | 1 | Measurement request, held until a result arrives |
| meas_valid | input | 1 | Measurement result valid |
| meas_setup | input | 4 | Measured setup delay |
| meas_hold | input | 4 | Measured hold delay |
| meas_sample | input | 4 | Proposed sample delay |
| meas_check | input | 1 | Phase measured in the correct data cycle |
| sample_delay | output | 4 | Sample delay applied to the delay line |
| irq | output | 1 | Drift interrupt |

## Verification
The assertions assume that `meas_valid` is a single-cycle pulse and that a result is meaningful only while `meas_req` is high. They also assume that a register write lasts exactly one cycle. The stimulus raises `meas_valid` for one cycle at a time, and outside a request only on purpose, to exercise R4. Writes are issued one per task, and `irq_en` changes only between measurements, so tracking eligibility is stable whenever a result is evaluated.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  localparam int unsigned SDT_DW   = 4;
  localparam int unsigned SDT_FRAC = 12;
  localparam int unsigned SDT_LW   = 4;
  localparam int unsigned SDT_LMAX = 12;
  localparam int unsigned SDT_TW   = 2;
  localparam int unsigned SDT_AW   = 2;
  localparam int unsigned SDT_RW   = 8;

  localparam logic [SDT_AW-1:0] ADR_DLY = 2'd0;
  localparam logic [SDT_AW-1:0] ADR_SMP = 2'd1;
  localparam logic [SDT_AW-1:0] ADR_CTL = 2'd2;
  localparam logic [SDT_AW-1:0] ADR_CMD = 2'd3;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} seq_st_e;

  typedef struct packed {
    logic              surv;
    logic              track;
    logic [SDT_LW-1:0] flen;
    logic [SDT_TW-1:0] thr;
  } ctl_t;
endpackage

// File: rtl/sdt_seq.sv
module sdt_seq
  import sdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic surv,
  input  logic start,
  input  logic meas_valid,
  output logic meas_req,
  output logic take
);
  seq_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (surv || start) state_d = ST_BUSY;
      ST_BUSY: if (meas_valid && !surv) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign meas_req = (state_q == ST_BUSY);
  assign take     = meas_req && meas_valid;
endmodule

// File: rtl/sdt_filter.sv
module sdt_filter #(
  parameter int unsigned DW   = 4,
  parameter int unsigned FRAC = 12,
  parameter int unsigned LW   = 4,
  parameter int unsigned LMAX = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] smp,
  input  logic [LW-1:0] flen,
  output logic [DW-1:0] rnd
);
  localparam int unsigned ACCW = DW + FRAC;
  localparam int unsigned SW   = ACCW + 1;
  localparam logic [LW-1:0] LCLIP = LW'(LMAX);
  localparam logic [ACCW:0] HALF = {{(DW+1){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  logic [ACCW-1:0]        acc_q, acc_d;
  logic                   primed_q, primed_d;
  logic [LW-1:0]          sh;
  logic signed [SW-1:0]   diff, step;
  logic [ACCW:0]          sum;

  assign sh   = (flen > LCLIP) ? LCLIP : flen;
  assign diff = $signed({1'b0, smp, {FRAC{1'b0}}}) - $signed({1'b0, acc_q});
  assign step = diff >>> sh;

  always_comb begin
    acc_d    = acc_q;
    primed_d = primed_q;
    if (take) begin
      primed_d = 1'b1;
      if (primed_q) acc_d = acc_q + step[ACCW-1:0];
      else          acc_d = {smp, {FRAC{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      primed_q <= 1'b0;
    end else if (take) begin
      acc_q    <= acc_d;
      primed_q <= primed_d;
    end
  end

  assign sum = {1'b0, acc_q} + HALF;
  assign rnd = sum[ACCW] ? {DW{1'b1}} : sum[ACCW-1:FRAC];
endmodule

// File: rtl/sdt_capture.sv
module sdt_capture #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] in_setup,
  input  logic [DW-1:0] in_hold,
  input  logic [DW-1:0] in_smp,
  input  logic          in_chk,
  output logic [DW-1:0] raw_setup,
  output logic [DW-1:0] raw_hold,
  output logic          change,
  output logic          check
);
  localparam int unsigned VW = 3 * DW;

  logic [VW-1:0] vec_q, vec_d;
  logic          seen_q;
  logic          chg_q, chg_d;
  logic          chk_q;

  assign vec_d = {in_setup, in_hold, in_smp};
  assign chg_d = seen_q && (vec_d != vec_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      seen_q <= 1'b0;
      chg_q  <= 1'b0;
      chk_q  <= 1'b0;
    end else if (take) begin
      vec_q  <= vec_d;
      seen_q <= 1'b1;
      chg_q  <= chg_d;
      chk_q  <= in_chk;
    end
  end

  assign raw_setup = vec_q[VW-1 -: DW];
  assign raw_hold  = vec_q[2*DW-1 -: DW];
  assign change    = chg_q;
  assign check     = chk_q;
endmodule

// File: rtl/sdt_regs.sv
module sdt_regs
  import sdt_pkg::*;
#(
  parameter int unsigned DW = 4,
  parameter int unsigned AW = 2,
  parameter int unsigned RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [RW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] raw_setup,
  input  logic [DW-1:0] raw_hold,
  input  logic [DW-1:0] filt,
  input  logic          change,
  input  logic          check,
  input  logic          irq_flag,
  output ctl_t          ctl,
  output logic          smp_wr,
  output logic [DW-1:0] smp_val,
  output logic          start,
  output logic          clr_irq,
  output logic [RW-1:0] rd_data
);
  logic [DW-1:0] wsetup_q, whold_q, wsmp_q;
  ctl_t          ctl_q;
  logic          dly_wr, ctl_wr, cmd_wr;

  assign dly_wr  = wr_en && (wr_addr == ADR_DLY);
  assign smp_wr  = wr_en && (wr_addr == ADR_SMP);
  assign ctl_wr  = wr_en && (wr_addr == ADR_CTL);
  assign cmd_wr  = wr_en && (wr_addr == ADR_CMD);
  assign start   = cmd_wr && wr_data[1];
  assign clr_irq = cmd_wr && wr_data[0];
  assign smp_val = wr_data[RW-1 -: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsetup_q <= '0;
      whold_q  <= '0;
    end else if (dly_wr) begin
      wsetup_q <= wr_data[RW-1 -: DW];
      whold_q  <= wr_data[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wsmp_q <= '0;
    else if (smp_wr) wsmp_q <= smp_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_t'(wr_data);
  end

  assign ctl = ctl_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_DLY: rd_data = ctl_q.track ? {raw_setup, raw_hold} : {wsetup_q, whold_q};
      ADR_SMP: rd_data = {(ctl_q.track ? filt : wsmp_q), change, 2'b00, check};
      ADR_CTL: rd_data = RW'(ctl_q);
      ADR_CMD: rd_data = {{(RW-1){1'b0}}, irq_flag};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sdt_ctrl.sv
module sdt_ctrl
  import sdt_pkg::*;
#(
  parameter int unsigned DW   = SDT_DW,
  parameter int unsigned FRAC = SDT_FRAC,
  parameter int unsigned LW   = SDT_LW,
  parameter int unsigned LMAX = SDT_LMAX,
  parameter int unsigned TW   = SDT_TW,
  parameter int unsigned AW   = SDT_AW,
  parameter int unsigned RW   = SDT_RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [RW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [RW-1:0] rd_data,
  input  logic          irq_en,
  output logic          meas_req,
  input  logic          meas_valid,
  input  logic [DW-1:0] meas_setup,
  input  logic [DW-1:0] meas_hold,
  input  logic [DW-1:0] meas_sample,
  input  logic          meas_check,
  output logic [DW-1:0] sample_delay,
  output logic          irq
);
  localparam logic [DW-1:0] ONE = DW'(1);

  ctl_t          ctl;
  logic          surv, track_bit, take, start, clr_irq, smp_wr;
  logic [DW-1:0] smp_val, filt, raw_setup, raw_hold;
  logic          change, check;
  logic          eval_q;
  logic          auto_eff, fire;
  logic [DW-1:0] drift, steps;
  logic [DW-1:0] applied_q, applied_d;
  logic          irq_flag_q, irq_flag_d;

  assign surv      = ctl.surv;
  assign track_bit = ctl.track;

  sdt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .surv(surv), .start(start),
    .meas_valid(meas_valid), .meas_req(meas_req), .take(take)
  );

  sdt_filter #(.DW(DW), .FRAC(FRAC), .LW(LW), .LMAX(LMAX)) u_filter (
    .clk(clk), .rst_n(rst_n), .take(take), .smp(meas_sample),
    .flen(ctl.flen), .rnd(filt)
  );

  sdt_capture #(.DW(DW)) u_capture (
    .clk(clk), .rst_n(rst_n), .take(take), .in_setup(meas_setup),
    .in_hold(meas_hold), .in_smp(meas_sample), .in_chk(meas_check),
    .raw_setup(raw_setup), .raw_hold(raw_hold), .change(change), .check(check)
  );

  sdt_regs #(.DW(DW), .AW(AW), .RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .raw_setup(raw_setup),
    .raw_hold(raw_hold), .filt(filt), .change(change), .check(check),
    .irq_flag(irq_flag_q), .ctl(ctl), .smp_wr(smp_wr), .smp_val(smp_val),
    .start(start), .clr_irq(clr_irq), .rd_data(rd_data)
  );

  // Evaluation runs one cycle after a result, on the updated accumulator.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eval_q <= 1'b0;
    else        eval_q <= take;
  end

  assign auto_eff = track_bit && surv && !irq_en;
  assign drift    = (filt >= applied_q) ? (filt - applied_q) : (applied_q - filt);
  assign steps    = {{(DW-TW){1'b0}}, ctl.thr} + ONE;
  assign fire     = eval_q && (drift >= steps);

  always_comb begin
    applied_d = applied_q;
    if (smp_wr)                applied_d = smp_val;
    else if (fire && auto_eff) applied_d = filt;
  end

  always_comb begin
    irq_flag_d = irq_flag_q;
    if (fire && surv && !auto_eff) irq_flag_d = 1'b1;
    else if (clr_irq)              irq_flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied_q  <= '0;
      irq_flag_q <= 1'b0;
    end else begin
      applied_q  <= applied_d;
      irq_flag_q <= irq_flag_d;
    end
  end

  assign sample_delay = applied_q;
  assign irq          = irq_flag_q && irq_en;
endmodule

// File: rtl/sdt_ctrl_chk.sv
module sdt_ctrl_chk #(
  parameter int unsigned DW = 4,
  parameter int unsigned AW = 2,
  parameter int unsigned RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          meas_req,
  input logic          meas_valid,
  input logic          surv,
  input logic          start,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [RW-1:0] wr_data,
  input logic          smp_wr,
  input logic          auto_eff,
  input logic          irq_flag,
  input logic [DW-1:0] sample_delay
);
  logic clr_wr;
  assign clr_wr = wr_en && (wr_addr == AW'(3)) && wr_data[0];

  AST_SINGLE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && meas_valid && !surv) |=> !meas_req); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!meas_req && !start && !surv) |=> !meas_req); // R2
  AST_CHAIN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && meas_valid && surv) |=> meas_req); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && !meas_valid) |=> meas_req); // R3
  AST_DELAY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sample_delay) && !$past(smp_wr)) |-> $past(auto_eff)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !clr_wr) |=> irq_flag); // R11
endmodule

bind sdt_ctrl sdt_ctrl_chk #(.DW(DW), .AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .meas_req(meas_req), .meas_valid(meas_valid),
  .surv(surv), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .smp_wr(smp_wr), .auto_eff(auto_eff),
  .irq_flag(irq_flag_q), .sample_delay(sample_delay)
);

// File: tb/sdt_ctrl_tb.sv
module sdt_ctrl_tb;
  logic       clk, rst_n;
  logic       wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       irq_en, meas_req, meas_valid, meas_check, irq;
  logic [3:0] meas_setup, meas_hold, meas_sample, sample_delay;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  sdt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_en(irq_en), .meas_req(meas_req), .meas_valid(meas_valid),
    .meas_setup(meas_setup), .meas_hold(meas_hold),
    .meas_sample(meas_sample), .meas_check(meas_check),
    .sample_delay(sample_delay), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic expect_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    irq_en = 1'b0; meas_valid = 1'b0; meas_setup = '0; meas_hold = '0;
    meas_sample = '0; meas_check = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    expect_eq(tag, int'(rd_data), int'(exp));
  endtask

  task automatic pulse_valid(input logic [3:0] s, input logic [3:0] h,
                             input logic [3:0] d, input logic c);
    meas_setup = s; meas_hold = h; meas_sample = d; meas_check = c;
    meas_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    meas_valid = 1'b0;
  endtask

  task automatic meas(input logic [3:0] s, input logic [3:0] h,
                      input logic [3:0] d, input logic c);
    while (!meas_req) @(negedge clk);
    pulse_valid(s, h, d, c);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    expect_eq("R1 sample_delay", int'(sample_delay), 0);
    expect_eq("R1 irq", int'(irq), 0);
    expect_eq("R1 meas_req", int'(meas_req), 0);
    for (int a = 0; a < 4; a++) rd_chk("R1 readback", 2'(a), 8'h00);
  endtask

  task automatic t_single();
    wr(2'd0, 8'h5A);
    wr(2'd2, 8'h00);
    expect_eq("R2 idle req", int'(meas_req), 0);
    pulse_valid(4'd9, 4'd9, 4'd9, 1'b0);
    expect_eq("R2 no req from stray valid", int'(meas_req), 0);
    wr(2'd3, 8'h02);
    expect_eq("R2 req after start", int'(meas_req), 1);
    meas(4'd3, 4'd4, 4'd6, 1'b1);
    expect_eq("R2 req drops", int'(meas_req), 0);
    pulse_valid(4'd9, 4'd9, 4'd9, 1'b0);
    repeat (2) @(negedge clk);
    expect_eq("R2 stays idle", int'(meas_req), 0);
    wr(2'd2, 8'h40);
    rd_chk("R4 stray valid ignored, R6 measured", 2'd0, 8'h34);
    rd_chk("R5 first load, R8 check", 2'd1, 8'h61);
    expect_eq("R10 no tracking without continuous", int'(sample_delay), 0);
    wr(2'd2, 8'h00);
    rd_chk("R6 written setup/hold", 2'd0, 8'h5A);
    rd_chk("R6 written sample", 2'd1, 8'h01);
  endtask

  task automatic t_change();
    wr(2'd3, 8'h02);
    meas(4'd3, 4'd4, 4'd6, 1'b0);
    rd_chk("R7 no change, R8 check 0", 2'd1, 8'h00);
    wr(2'd3, 8'h02);
    meas(4'd3, 4'd5, 4'd6, 1'b1);
    rd_chk("R7 change set", 2'd1, 8'h09);
  endtask

  task automatic t_surv();
    wr(2'd1, 8'h50);
    expect_eq("R12 applied from write", int'(sample_delay), 5);
    rd_chk("R12 written sample readback", 2'd1, 8'h59);
    irq_en = 1'b1;
    wr(2'd2, 8'h81);
    meas(4'd3, 4'd5, 4'd6, 1'b1);
    expect_eq("R9 drift 1 below threshold", int'(irq), 0);
    expect_eq("R3 back to back", int'(meas_req), 1);
    meas(4'd3, 4'd5, 4'd7, 1'b1);
    expect_eq("R11 irq on drift 2", int'(irq), 1);
    rd_chk("R11 flag readback", 2'd3, 8'h01);
    irq_en = 1'b0; #1;
    expect_eq("R11 irq gated", int'(irq), 0);
    rd_chk("R11 flag sticky", 2'd3, 8'h01);
    irq_en = 1'b1;
    wr(2'd3, 8'h01);
    expect_eq("R11 irq cleared", int'(irq), 0);
    wr(2'd2, 8'h01);
    expect_eq("R3 open request finishes", int'(meas_req), 1);
    meas(4'd3, 4'd5, 4'd7, 1'b1);
    expect_eq("R3 halt after cycle", int'(meas_req), 0);
    expect_eq("R11 no irq when halted", int'(irq), 0);
    expect_eq("R10 no update without tracking", int'(sample_delay), 5);
  endtask

  task automatic t_track();
    do_reset();
    wr(2'd2, 8'hC4);
    meas(4'd0, 4'd0, 4'd8, 1'b1);
    expect_eq("R10 applied 8", int'(sample_delay), 8);
    rd_chk("R5 filtered readback", 2'd1, 8'h81);
    meas(4'd0, 4'd0, 4'd12, 1'b1);
    expect_eq("R5 half step", int'(sample_delay), 10);
    meas(4'd0, 4'd0, 4'd11, 1'b1);
    expect_eq("R5 round half up", int'(sample_delay), 11);
    wr(2'd2, 8'hFC);
    meas(4'd0, 4'd0, 4'd10, 1'b1);
    expect_eq("R5 clipped shift down", int'(sample_delay), 10);
    meas(4'd0, 4'd0, 4'd15, 1'b1);
    expect_eq("R5 clipped shift up", int'(sample_delay), 11);
    wr(2'd2, 8'hC2);
    meas(4'd0, 4'd0, 4'd13, 1'b1);
    expect_eq("R9 drift 2 under code 2", int'(sample_delay), 11);
    meas(4'd0, 4'd0, 4'd14, 1'b1);
    expect_eq("R9 drift 3 fires", int'(sample_delay), 14);
    irq_en = 1'b1;
    meas(4'd0, 4'd0, 4'd2, 1'b1);
    expect_eq("R10 irq_en blocks tracking", int'(sample_delay), 14);
    expect_eq("R11 irq instead", int'(irq), 1);
  endtask

  initial begin
    t_reset();
    t_single();
    t_change();
    t_surv();
    t_track();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule